// File: doc/BRIEF.md
# Command-Driven Parallel NOR Flash Model

This block is a synchronous bus slave that acts like a parallel NOR flash driven by a command set. It holds a small byte-wide storage array. Bus writes never reach the array directly. A small state machine treats them as command cycles, and those cycles decide what later bus reads return: array contents, an 8-bit status byte, or bytes from a built-in device description table.

The command set covers block erase with a confirm cycle, buffered programming with a word count, status clear, a status-read mode, lock setup (accepted but without effect) and a query mode. Each access carries a byte-lane size, so one bus cycle can read or program 1, 2 or 4 bytes in little-endian lane order. The parameters are the block size, the block count and the device word width, which sets how query addresses are scaled. Erase and program take effect in the same clock edge as the command write. Reads are registered.

Top module: `nor_cmd_flash`

## Requirements
- R1: After a synchronous active-high reset, every storage byte is 0xFF, the status byte is 0x00, `bus_rdata` is zero and the device is in array-read mode.
- R2: A read (`bus_rd` high) updates `bus_rdata` at the next rising edge, and `bus_rdata` holds while `bus_rd` is low. In array mode, `bus_size` selects the byte count: 0 reads 1 byte, 1 reads 2 bytes, 2 or 3 reads 4 bytes. Byte address+k appears on bits [8k+7:8k], and lanes that are not read return zero.
- R3: Writing 0xFF or 0x00 as a first-cycle command selects array-read mode.
- R4: Writing 0x50 as a first-cycle command sets the status byte to 0x00 and selects array-read mode.
- R5: Writing 0x70 selects status mode. Reads then return the status byte zero-extended to 32 bits, whose bit 7 is the ready flag. The next write is decoded as a fresh first-cycle command.
- R6: Writing 0x20 erases at once the whole block that contains the write address (address with its low log2(block size) bits cleared), filling it with 0xFF and setting ready. In the next cycle, 0xD0 sets ready and keeps the erase state, 0xFF returns to array mode, and any other value also returns to array mode.
- R7: Writing 0x E8 sets ready. The next write's low byte is a count N. The following N+1 writes each program `bus_size` bytes of `bus_wdata` at their address and set ready. A closing 0xD0 then returns to the first-cycle state with status reads. Any other closing value returns to array mode.
- R8: Writing 0x60 followed by 0xD0 or 0x01 returns to the first-cycle state with ready set and status reads. Any other second value selects array mode. Locking never blocks later erase or program.
- R9: Writing 0x98 selects query mode. A read returns table byte number (address[7:0] >> s) zero-extended, where s is 0, 1 or 2 for a 1-, 2- or 4-byte device word. Numbers 82 and above read as 0. Writes other than 0xFF stay in query mode, and 0xFF selects array mode.
- R10: The query table holds 0x51, 0x52, 0x59 at 0x10..0x12, 0x01 at 0x13, 0x00 at 0x14, log2(total bytes) at 0x27, 0x01 at 0x2C, block count minus one as a 16-bit little-endian value at 0x2D/0x2E, block size bits [15:8] and [23:16] at 0x2F/0x30, and 0x00 elsewhere.
- R11: While the held command is erase (0x20), lock (0x60), status (0x70) or buffered write (0xE8), reads return the status byte instead of array data.
- R12: Any first-cycle command value not listed above selects array-read mode with no held command, and leaves storage and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | log2(BLK_BYTES*BLK_COUNT) | Byte address |
| bus_wdata | input | 32 | Write data; low byte is the command code |
| bus_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |

## Verification
The command interpreter is driven through every mode-changing path: clean sequences, aborts with 0xFF, and bad confirm values or unknown codes. Each path is followed by a read, so that array, status and query results can be told apart. Status and array results are chosen so they differ: erased array words read 0xFFFFFFFF, while status reads 0x00 or 0x80. Programs use 1-, 2- and 4-byte lanes with distinct patterns, so lane order and size masking show up. After each erase and program, a byte sweep over the whole array is compared against a bench model. This shows that an erase touches exactly one block. A sweep of all 128 query indices against arithmetically computed table values checks the address scaling and the zero region.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ARG  = 2'd1,
      PH_DATA = 2'd2,
      PH_CONF = 2'd3
   } phase_t;

   localparam logic [7:0] OP_ARRAY   = 8'hFF;
   localparam logic [7:0] OP_NOP     = 8'h00;
   localparam logic [7:0] OP_ERASE   = 8'h20;
   localparam logic [7:0] OP_CLRSTS  = 8'h50;
   localparam logic [7:0] OP_LOCK    = 8'h60;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] OP_QUERY   = 8'h98;
   localparam logic [7:0] OP_BUFWR   = 8'hE8;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_UNLK    = 8'h01;

   localparam int QUERY_LEN = 82;

endpackage

// File: rtl/pfc_seq.sv
module pfc_seq
   import pfc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       wr,
   input  logic [7:0] op,
   output logic       erase_go,
   output logic       prog_go,
   output logic [7:0] mode_q,
   output logic [7:0] status_q
);

   phase_t     phase_q;
   logic [7:0] cnt_q;

   always_comb begin
      erase_go = wr && (phase_q == PH_IDLE) && (op == OP_ERASE);
      prog_go  = wr && (phase_q == PH_DATA);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q  <= PH_IDLE;
         mode_q   <= OP_NOP;
         status_q <= 8'h00;
         cnt_q    <= 8'h00;
      end else if (wr) begin
         unique case (phase_q)
            PH_IDLE: begin
               case (op)
                  OP_ERASE, OP_BUFWR: begin
                     status_q[7] <= 1'b1;
                     phase_q     <= PH_ARG;
                     mode_q      <= op;
                  end
                  OP_LOCK, OP_QUERY: begin
                     phase_q <= PH_ARG;
                     mode_q  <= op;
                  end
                  OP_STATUS: mode_q <= op;
                  OP_CLRSTS: begin
                     status_q <= 8'h00;
                     mode_q   <= OP_NOP;
                  end
                  default:   mode_q <= OP_NOP;
               endcase
            end
            PH_ARG: begin
               case (mode_q)
                  OP_ERASE: begin
                     if (op == OP_CONFIRM) status_q[7] <= 1'b1;
                     else begin
                        phase_q <= PH_IDLE;
                        mode_q  <= OP_NOP;
                     end
                  end
                  OP_BUFWR: begin
                     cnt_q   <= op;
                     phase_q <= PH_DATA;
                  end
                  OP_LOCK: begin
                     phase_q <= PH_IDLE;
                     if (op == OP_CONFIRM || op == OP_UNLK) status_q[7] <= 1'b1;
                     else mode_q <= OP_NOP;
                  end
                  OP_QUERY: begin
                     if (op == OP_ARRAY) begin
                        phase_q <= PH_IDLE;
                        mode_q  <= OP_NOP;
                     end
                  end
                  default: begin
                     phase_q <= PH_IDLE;
                     mode_q  <= OP_NOP;
                  end
               endcase
            end
            PH_DATA: begin
               status_q[7] <= 1'b1;
               if (cnt_q == 8'h00) phase_q <= PH_CONF;
               cnt_q <= cnt_q - 8'd1;
            end
            PH_CONF: begin
               phase_q <= PH_IDLE;
               if (op == OP_CONFIRM) status_q[7] <= 1'b1;
               else mode_q <= OP_NOP;
            end
         endcase
      end
   end

   // R4: clear-status empties the status byte
   p_clear_status_r4: assert property (@(posedge clk) disable iff (rst)
      (wr && phase_q == PH_IDLE && op == OP_CLRSTS) |=> (status_q == 8'h00 && mode_q == OP_NOP));

   // R6: erase confirm leaves ready set
   p_erase_ready_r6: assert property (@(posedge clk) disable iff (rst)
      (wr && phase_q == PH_ARG && mode_q == OP_ERASE && op == OP_CONFIRM) |=> status_q[7]);

   // R7: data phase only exists under a buffered write
   p_data_phase_r7: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_DATA || phase_q == PH_CONF) |-> (mode_q == OP_BUFWR));

   // R12: unknown first-cycle code drops back to array mode
   p_bad_idle_r12: assert property (@(posedge clk) disable iff (rst)
      (wr && phase_q == PH_IDLE && op != OP_ERASE && op != OP_BUFWR && op != OP_LOCK &&
       op != OP_QUERY && op != OP_STATUS && op != OP_CLRSTS)
      |=> (mode_q == OP_NOP && phase_q == PH_IDLE && $stable(status_q)));

endmodule

// File: rtl/pfc_array.sv
module pfc_array #(
   parameter int BLK_BYTES = 32,
   parameter int BLK_COUNT = 8,
   parameter int DATA_W    = 32,
   localparam int DEPTH    = BLK_BYTES * BLK_COUNT,
   localparam int AW       = $clog2(DEPTH),
   localparam int BLK_AW   = $clog2(BLK_BYTES),
   localparam int LANES    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              erase_go,
   input  logic              prog_go,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [1:0]        size,
   output logic [DATA_W-1:0] rd_word
);

   logic [7:0] mem [DEPTH];
   int         nlanes;

   always_comb begin
      case (size)
         2'd0:    nlanes = 1;
         2'd1:    nlanes = 2;
         default: nlanes = 4;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (erase_go) begin
         for (int i = 0; i < DEPTH; i++)
            if ((i >> BLK_AW) == int'(addr[AW-1:BLK_AW])) mem[i] <= 8'hFF;
      end else if (prog_go) begin
         for (int k = 0; k < LANES; k++)
            if (k < nlanes) mem[AW'(int'(addr) + k)] <= wdata[8*k +: 8];
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign rd_word[8*k +: 8] = (k < nlanes) ? mem[AW'(int'(addr) + k)] : 8'h00;
   end

   // R6: first byte of the addressed block is erased
   p_erase_fill_r6: assert property (@(posedge clk) disable iff (rst)
      erase_go |=> (mem[{$past(addr[AW-1:BLK_AW]), {BLK_AW{1'b0}}}] == 8'hFF));

   // R7: programmed low lane holds the written byte
   p_prog_lane0_r7: assert property (@(posedge clk) disable iff (rst)
      prog_go |=> (mem[$past(addr)] == $past(wdata[7:0])));

endmodule

// File: rtl/pfc_query.sv
module pfc_query #(
   parameter int TOTAL_LOG2 = 8,
   parameter int BLK_COUNT  = 8,
   parameter int BLK_BYTES  = 32
) (
   input  logic [7:0] idx,
   output logic [7:0] qbyte
);

   localparam logic [15:0] CNT_M1 = 16'(BLK_COUNT - 1);
   localparam logic [31:0] BSIZE  = 32'(BLK_BYTES);

   always_comb begin
      case (idx)
         8'h10:   qbyte = 8'h51;
         8'h11:   qbyte = 8'h52;
         8'h12:   qbyte = 8'h59;
         8'h13:   qbyte = 8'h01;
         8'h27:   qbyte = 8'(TOTAL_LOG2);
         8'h2C:   qbyte = 8'h01;
         8'h2D:   qbyte = CNT_M1[7:0];
         8'h2E:   qbyte = CNT_M1[15:8];
         8'h2F:   qbyte = BSIZE[15:8];
         8'h30:   qbyte = BSIZE[23:16];
         default: qbyte = 8'h00;
      endcase
   end

endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
   import pfc_pkg::*;
#(
   parameter int BLK_BYTES = 32,
   parameter int BLK_COUNT = 8,
   parameter int DEV_BYTES = 2,
   localparam int TOTAL    = BLK_BYTES * BLK_COUNT,
   localparam int AW       = $clog2(TOTAL)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   input  logic [1:0]    bus_size,
   input  logic          bus_wr,
   input  logic          bus_rd,
   output logic [31:0]   bus_rdata
);

   localparam int QSHIFT = (DEV_BYTES == 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;

   if ((BLK_BYTES & (BLK_BYTES - 1)) != 0 || BLK_BYTES < 4) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two of at least 4");
   end
   if ((BLK_COUNT & (BLK_COUNT - 1)) != 0 || BLK_COUNT < 2) begin : g_bad_cnt
      $error("BLK_COUNT must be a power of two of at least 2");
   end
   if (DEV_BYTES != 1 && DEV_BYTES != 2 && DEV_BYTES != 4) begin : g_bad_dev
      $error("DEV_BYTES must be 1, 2 or 4");
   end

   logic       erase_go, prog_go;
   logic [7:0] mode_q, status_q;
   logic [31:0] arr_word;
   logic [7:0] low8, qidx, qbyte;
   logic [31:0] rd_next;

   pfc_seq u_seq (
      .clk      (clk),
      .rst      (rst),
      .wr       (bus_wr),
      .op       (bus_wdata[7:0]),
      .erase_go (erase_go),
      .prog_go  (prog_go),
      .mode_q   (mode_q),
      .status_q (status_q)
   );

   pfc_array #(.BLK_BYTES(BLK_BYTES), .BLK_COUNT(BLK_COUNT), .DATA_W(32)) u_array (
      .clk      (clk),
      .rst      (rst),
      .erase_go (erase_go),
      .prog_go  (prog_go),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .size     (bus_size),
      .rd_word  (arr_word)
   );

   if (AW >= 8) begin : g_low_wide
      assign low8 = bus_addr[7:0];
   end else begin : g_low_narrow
      assign low8 = 8'(bus_addr);
   end

   assign qidx = low8 >> QSHIFT;

   pfc_query #(.TOTAL_LOG2(AW), .BLK_COUNT(BLK_COUNT), .BLK_BYTES(BLK_BYTES)) u_query (
      .idx   (qidx),
      .qbyte (qbyte)
   );

   always_comb begin
      if (mode_q == OP_NOP)        rd_next = arr_word;
      else if (mode_q == OP_QUERY) rd_next = (int'(qidx) >= QUERY_LEN) ? 32'h0 : {24'h0, qbyte};
      else                         rd_next = {24'h0, status_q};
   end

   always_ff @(posedge clk) begin
      if (rst)         bus_rdata <= 32'h0;
      else if (bus_rd) bus_rdata <= rd_next;
   end

   // R2: read data holds without a read strobe
   p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |=> $stable(bus_rdata));

   // R9: query numbers past the table read as zero
   p_query_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && mode_q == OP_QUERY && int'(qidx) >= QUERY_LEN) |=> (bus_rdata == 32'h0));

   // R11: status-type modes return the status byte
   p_status_read_r11: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && (mode_q == OP_STATUS || mode_q == OP_ERASE || mode_q == OP_LOCK ||
                  mode_q == OP_BUFWR)) |=> (bus_rdata[31:8] == 24'h0));

endmodule

// File: tb/nor_cmd_flash_tb.sv
`timescale 1ns/1ps
module nor_cmd_flash_tb;

   localparam int BLK_BYTES = 32;
   localparam int BLK_COUNT = 8;
   localparam int TOTAL     = BLK_BYTES * BLK_COUNT;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [1:0]  bus_size = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;

   int tests = 0;
   int fails = 0;
   logic [7:0] model [TOTAL];

   always #4 clk = ~clk;

   nor_cmd_flash #(.BLK_BYTES(BLK_BYTES), .BLK_COUNT(BLK_COUNT), .DEV_BYTES(2)) u_dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
   );

   function automatic int lanes(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [31:0] arr_exp(input logic [7:0] a, input logic [1:0] sz);
      logic [31:0] w = '0;
      for (int k = 0; k < lanes(sz); k++) w[8*k +: 8] = model[8'(a + k)];
      return w;
   endfunction

   function automatic logic [7:0] q_exp(input int i);
      case (i)
         16: return 8'h51;
         17: return 8'h52;
         18: return 8'h59;
         19: return 8'h01;
         39: return 8'd8;
         44: return 8'h01;
         45: return 8'(BLK_COUNT - 1);
         46: return 8'((BLK_COUNT - 1) >> 8);
         47: return 8'(BLK_BYTES >> 8);
         48: return 8'(BLK_BYTES >> 16);
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic prog(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
      wr(a, d, sz);
      for (int k = 0; k < lanes(sz); k++) model[8'(a + k)] = d[8*k +: 8];
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [1:0] sz,
                         input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_size = sz; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      check(bus_rdata, exp, tag);
   endtask

   task automatic sweep(input string tag);
      for (int i = 0; i < TOTAL; i++) rd_chk(8'(i), 2'd0, {24'h0, model[i]}, tag);
   endtask

   task automatic erase_model(input logic [7:0] a);
      for (int i = 0; i < TOTAL; i++) if (i / BLK_BYTES == int'(a) / BLK_BYTES) model[i] = 8'hFF;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < TOTAL; i++) model[i] = 8'hFF;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check(bus_rdata, 32'h0, "R1 rdata after reset");
      rd_chk(8'h00, 2'd2, 32'hFFFF_FFFF, "R1 erased array after reset");
      sweep("R1 array sweep after reset");
      wr(8'h00, 32'h70, 2'd0);
      rd_chk(8'h00, 2'd2, 32'h0, "R1 R5 status zero after reset");

      // R7 buffered program, 4-byte lanes
      wr(8'h40, 32'hE8, 2'd0);
      rd_chk(8'h40, 2'd2, 32'h80, "R7 ready after buffer start");
      wr(8'h40, 32'h03, 2'd0);
      for (int i = 0; i < 4; i++) prog(8'(8'h40 + 4 * i), 32'hA0B1C2D3 + 32'h01010101 * i, 2'd2);
      rd_chk(8'h40, 2'd2, 32'h80, "R7 R11 status while awaiting confirm");
      wr(8'h40, 32'hD0, 2'd0);
      rd_chk(8'h40, 2'd2, 32'h80, "R7 status after confirm");
      wr(8'h00, 32'hFF, 2'd0);
      sweep("R7 sweep after word program");
      rd_chk(8'h40, 2'd1, 32'h0000C2D3, "R2 two-byte read lanes");
      rd_chk(8'h44, 2'd2, 32'hA1B2C3D4, "R2 four-byte little-endian read");
      rd_chk(8'h41, 2'd0, 32'h000000C2, "R2 one-byte read");

      // R7 byte and halfword programs
      wr(8'h00, 32'hE8, 2'd0); wr(8'h00, 32'h00, 2'd0);
      prog(8'h03, 32'hFFFF_FF5A, 2'd0);
      wr(8'h00, 32'hD0, 2'd0); wr(8'h00, 32'hFF, 2'd0);
      rd_chk(8'h00, 2'd2, 32'h5AFFFFFF, "R7 byte program masks lanes");
      wr(8'h00, 32'hE8, 2'd0); wr(8'h00, 32'h01, 2'd0);
      prog(8'h10, 32'h5555_1234, 2'd1);
      prog(8'h12, 32'h6666_ABCD, 2'd1);
      wr(8'h00, 32'hD0, 2'd0); wr(8'h00, 32'hFF, 2'd0);
      rd_chk(8'h10, 2'd2, 32'hABCD1234, "R7 halfword programs");
      rd_chk(8'h14, 2'd2, 32'hFFFFFFFF, "R7 halfword program stays in range");

      // R6 erase block 2
      wr(8'h47, 32'h20, 2'd0); erase_model(8'h47);
      rd_chk(8'h00, 2'd2, 32'h80, "R6 R11 status after erase start");
      wr(8'h47, 32'hD0, 2'd0);
      rd_chk(8'h00, 2'd2, 32'h80, "R6 ready after confirm");
      wr(8'h00, 32'hFF, 2'd0);
      sweep("R6 sweep after erase of one block");
      rd_chk(8'h10, 2'd2, 32'hABCD1234, "R6 other block untouched");

      // R6 erase with bad confirm
      wr(8'h05, 32'h20, 2'd0); erase_model(8'h05);
      wr(8'h05, 32'h33, 2'd0);
      rd_chk(8'h00, 2'd2, 32'hFFFFFFFF, "R6 bad confirm returns array");
      sweep("R6 sweep after block 0 erase");

      // R4 clear status
      wr(8'h00, 32'h50, 2'd0);
      rd_chk(8'h00, 2'd2, 32'hFFFFFFFF, "R4 array mode after clear");
      wr(8'h00, 32'h70, 2'd0);
      rd_chk(8'h00, 2'd2, 32'h0, "R4 R5 status cleared");

      // R8 lock
      wr(8'h00, 32'h60, 2'd0); wr(8'h00, 32'hD0, 2'd0);
      rd_chk(8'h00, 2'd2, 32'h80, "R8 lock confirm sets ready");
      wr(8'h00, 32'h12, 2'd0);
      rd_chk(8'h00, 2'd2, 32'hFFFFFFFF, "R12 unknown code to array");
      wr(8'h00, 32'h70, 2'd0);
      rd_chk(8'h00, 2'd2, 32'h80, "R12 status untouched by unknown code");
      wr(8'h00, 32'h60, 2'd0); wr(8'h00, 32'h77, 2'd0);
      rd_chk(8'h00, 2'd2, 32'hFFFFFFFF, "R8 bad lock value to array");
      wr(8'h00, 32'h60, 2'd0); wr(8'h00, 32'h01, 2'd0);
      rd_chk(8'h00, 2'd2, 32'h80, "R8 unlock value sets ready");
      wr(8'h00, 32'hE8, 2'd0); wr(8'h00, 32'h00, 2'd0);
      prog(8'h00, 32'h99, 2'd0);
      wr(8'h00, 32'hD0, 2'd0); wr(8'h00, 32'hFF, 2'd0);
      rd_chk(8'h00, 2'd0, 32'h99, "R8 lock has no effect on program");

      // R3 exits
      wr(8'h00, 32'h70, 2'd0); wr(8'h00, 32'h00, 2'd0);
      rd_chk(8'h00, 2'd0, 32'h99, "R3 zero code to array");
      wr(8'h00, 32'h70, 2'd0); wr(8'h00, 32'hFF, 2'd0);
      rd_chk(8'h00, 2'd0, 32'h99, "R3 FF code to array");

      // R9 R10 query
      wr(8'h00, 32'h98, 2'd0);
      for (int i = 0; i < 128; i++) rd_chk(8'(2 * i), 2'd2, {24'h0, q_exp(i)}, "R9 R10 query sweep");
      rd_chk(8'h21, 2'd2, 32'h51, "R9 odd byte maps to same index");
      rd_chk(8'hA4, 2'd2, 32'h0, "R9 index 82 reads zero");
      wr(8'h00, 32'h42, 2'd0);
      rd_chk(8'h24, 2'd2, 32'h59, "R9 non-FF write stays in query");
      wr(8'h00, 32'hFF, 2'd0);
      rd_chk(8'h00, 2'd0, 32'h99, "R9 FF exits query");

      // R7 bad closing value
      wr(8'h00, 32'hE8, 2'd0); wr(8'h00, 32'h00, 2'd0);
      prog(8'h80, 32'h77, 2'd0);
      wr(8'h00, 32'h33, 2'd0);
      rd_chk(8'h80, 2'd0, 32'h77, "R7 bad closing value to array");
      sweep("R7 final sweep");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule